// File: doc/BRIEF.md
# Register-Mapped SPI Master with Data Queues

This block is a single-master SPI controller that a processor drives through a small 32-bit register bus. Software writes words into a transmit queue and reads received words out of a receive queue. It sets the clock mode, the bit order and loopback in a control register, and picks the slave through an active-low select register. A word holds `DATA_W` bits. The serial clock runs at a fixed ratio to the system clock, set by `CLK_DIV` at build time. The queue depth is `FIFO_DEPTH`.

A typical burst works like this. Software sets the hold bit and fills the transmit queue. It then clears the hold bit, and the engine shifts every queued word with no idle cycle between words. Each word shifted out puts exactly one received word into the receive queue, and software drains that queue afterwards. Software can find the queue depth by writing words until the full flag rises.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, control (0x60) reads 0, slave select (0x70) reads 0xFFFFFFFF, SCLK is low and every select pin is high.
- R2: Control bits are loopback=0, enable=1, master=2, CPOL=3, CPHA=4, TX flush=5, RX flush=6, manual select=7, hold=8, LSB first=9. Every bit reads back except 5 and 6, which read 0. Writing 1 to bit 5 or bit 6 empties the matching queue in one cycle.
- R3: Status (0x64) bits are RX empty=0, RX full=1, TX empty=2, TX full=3. After reset it reads 0x05.
- R4: While the hold bit is set, writes to TX data (0x68) only fill the queue and SCLK does not toggle. Clearing the bit sends all queued words back to back, one word every 2·DATA_W·CLK_DIV+1 cycles.
- R5: Each word shifted pushes exactly one word into the RX queue, read at 0x6C. In loopback the received word equals the word sent. With loopback off, the word is taken from MISO.
- R6: SCLK idles at CPOL. With CPHA=0, data is sampled on the first edge of each bit. With CPHA=1, data is sampled on the second edge.
- R7: Words go out MSB first when bit 9 is 0 and LSB first when it is 1.
- R8: In manual mode the select pins follow the low bits of the select register. In automatic mode they stay high except while a word is being shifted, when they take the register value.
- R9: Writing TX data after reset until TX full sets counts exactly FIFO_DEPTH writes. A write while the queue is full is dropped.
- R10: A read of RX data while the RX queue is empty returns 0 and leaves the queue empty.
- R11: No word starts unless both enable and master are set.
- R12: Status bit 4 (mode fault) always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | SEL_W | Active-low slave selects |

## Verification
A register write takes effect at the next clock edge, and read data appears one cycle after the strobe. The bench drives the bus at falling edges and samples `bus_rdata` at the falling edge that follows. A word finishes 2·DATA_W·CLK_DIV+1 cycles after it starts, and its received word is in the queue one cycle later. After a release the bench waits exactly that many cycles per word, plus a two-cycle margin, before it reads status. If a gap appears between words, the RX-full check fails. A monitor watches SCLK edges and samples MOSI and the select pins on the edge that the mode defines as the sampling edge. It collects the sampled bits so that bit order and phase can be compared with a value computed in the bench.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam logic [7:0] ADR_CTRL = 8'h60;
  localparam logic [7:0] ADR_STAT = 8'h64;
  localparam logic [7:0] ADR_TXD  = 8'h68;
  localparam logic [7:0] ADR_RXD  = 8'h6C;
  localparam logic [7:0] ADR_SEL  = 8'h70;

  localparam int CB_LOOP  = 0;
  localparam int CB_EN    = 1;
  localparam int CB_MST   = 2;
  localparam int CB_CPOL  = 3;
  localparam int CB_CPHA  = 4;
  localparam int CB_TXRST = 5;
  localparam int CB_RXRST = 6;
  localparam int CB_MAN   = 7;
  localparam int CB_HOLD  = 8;
  localparam int CB_LSB   = 9;

  typedef struct packed {
    logic lsb;
    logic hold;
    logic man;
    logic cpha;
    logic cpol;
    logic mst;
    logic en;
    logic loop;
  } ctrl_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = AW + 1;

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CNTW-1:0] cnt;
  logic            push, pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNTW'(DEPTH));
  assign push    = wr_en && !full;
  assign pop     = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: a push offered to a full queue leaves it full
  a_r9_full_drops: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && !clr) |=> full);
  // R10: a pop offered to an empty queue leaves it empty
  a_r10_empty_holds: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en) |=> empty);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int W   = 8,
  parameter int DIV = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic         loopback,
  input  logic         miso_i,
  output logic         busy,
  output logic         sclk_o,
  output logic         mosi_o,
  output logic         rx_valid,
  output logic [W-1:0] rx_word
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int EW = $clog2(2 * W);
  localparam int BW = $clog2(W);

  logic [CW-1:0] div_q;
  logic [EW-1:0] edge_q;
  logic [BW-1:0] cur_q;
  logic [W-1:0]  txw, rxw;
  logic          cpha_q, lsb_q, loop_q;
  logic          tick, lead, drive_ev, samp_ev, din;
  logic [BW-1:0] samp_idx;

  function automatic logic [BW-1:0] wire_pos(input logic [BW-1:0] i, input logic lsb);
    return lsb ? i : BW'(W - 1) - i;
  endfunction

  always_comb begin
    tick     = busy && (div_q == CW'(DIV - 1));
    lead     = !edge_q[0];
    drive_ev = tick && (cpha_q ? lead : !lead);
    samp_ev  = tick && (cpha_q ? !lead : lead);
    samp_idx = edge_q[EW-1:1];
    mosi_o   = txw[wire_pos(cur_q, lsb_q)];
    din      = loop_q ? mosi_o : miso_i;
  end

  assign rx_word = rxw;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sclk_o   <= 1'b0;
      div_q    <= '0;
      edge_q   <= '0;
      cur_q    <= '0;
      txw      <= '0;
      rxw      <= '0;
      rx_valid <= 1'b0;
      cpha_q   <= 1'b0;
      lsb_q    <= 1'b0;
      loop_q   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!busy) begin
        sclk_o <= cpol;
        if (start) begin
          busy   <= 1'b1;
          txw    <= tx_word;
          rxw    <= '0;
          div_q  <= '0;
          edge_q <= '0;
          cur_q  <= '0;
          cpha_q <= cpha;
          lsb_q  <= lsb_first;
          loop_q <= loopback;
        end
      end else if (tick) begin
        div_q  <= '0;
        sclk_o <= ~sclk_o;
        edge_q <= edge_q + 1'b1;
        if (drive_ev) cur_q <= cpha_q ? samp_idx : samp_idx + 1'b1;
        if (samp_ev) rxw[wire_pos(samp_idx, lsb_q)] <= din;
        if (edge_q == EW'(2 * W - 1)) begin
          busy     <= 1'b0;
          rx_valid <= 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R6: while idle, the clock line rests at the polarity level
  a_r6_idle_level: assert property (@(posedge clk) disable iff (rst)
    ($past(!busy) && !busy) |-> (sclk_o == $past(cpol)));
  // R5: each finished word raises exactly one single-cycle push
  a_r5_single_push: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int CLK_DIV    = 2,
  parameter int SEL_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [SEL_W-1:0]  ss_n_o
);
  ctrl_t              ctrl;
  logic [31:0]        sel_q;
  logic               tx_clr, rx_clr;
  logic               tx_empty, tx_full, rx_empty, rx_full;
  logic [DATA_W-1:0]  tx_q, rx_q, rx_word;
  logic               busy, start, rx_valid;
  logic               wr_ctrl, wr_sel, tx_push, rx_pop;
  logic [31:0]        stat_rd, ctrl_rd;

  assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
  assign wr_sel  = bus_wr && (bus_addr == ADR_SEL);
  assign tx_push = bus_wr && (bus_addr == ADR_TXD);
  assign rx_pop  = bus_rd && (bus_addr == ADR_RXD) && !rx_empty;
  assign start   = !busy && !tx_empty && ctrl.en && ctrl.mst && !ctrl.hold;
  assign stat_rd = {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
  assign ctrl_rd = {22'd0, ctrl.lsb, ctrl.hold, ctrl.man, 2'b00,
                    ctrl.cpha, ctrl.cpol, ctrl.mst, ctrl.en, ctrl.loop};

  spi_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .wr_en(tx_push), .wr_data(bus_wdata[DATA_W-1:0]),
    .rd_en(start), .rd_data(tx_q),
    .empty(tx_empty), .full(tx_full));

  spi_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .wr_en(rx_valid), .wr_data(rx_word),
    .rd_en(rx_pop), .rd_data(rx_q),
    .empty(rx_empty), .full(rx_full));

  spi_shift_engine #(.W(DATA_W), .DIV(CLK_DIV)) u_eng (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_q),
    .cpol(ctrl.cpol), .cpha(ctrl.cpha), .lsb_first(ctrl.lsb),
    .loopback(ctrl.loop), .miso_i(miso_i), .busy(busy),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .rx_valid(rx_valid),
    .rx_word(rx_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      sel_q     <= '1;
      tx_clr    <= 1'b0;
      rx_clr    <= 1'b0;
      bus_rdata <= '0;
      ss_n_o    <= '1;
    end else begin
      tx_clr <= wr_ctrl && bus_wdata[CB_TXRST];
      rx_clr <= wr_ctrl && bus_wdata[CB_RXRST];
      if (wr_ctrl) begin
        ctrl.loop <= bus_wdata[CB_LOOP];
        ctrl.en   <= bus_wdata[CB_EN];
        ctrl.mst  <= bus_wdata[CB_MST];
        ctrl.cpol <= bus_wdata[CB_CPOL];
        ctrl.cpha <= bus_wdata[CB_CPHA];
        ctrl.man  <= bus_wdata[CB_MAN];
        ctrl.hold <= bus_wdata[CB_HOLD];
        ctrl.lsb  <= bus_wdata[CB_LSB];
      end
      if (wr_sel) sel_q <= bus_wdata;
      if (bus_rd) begin
        case (bus_addr)
          ADR_CTRL: bus_rdata <= ctrl_rd;
          ADR_STAT: bus_rdata <= stat_rd;
          ADR_RXD:  bus_rdata <= rx_empty ? 32'd0 : 32'(rx_q);
          ADR_SEL:  bus_rdata <= sel_q;
          default:  bus_rdata <= 32'd0;
        endcase
      end
      if (ctrl.man || busy || start) ss_n_o <= sel_q[SEL_W-1:0];
      else                           ss_n_o <= '1;
    end
  end

  // R4: with hold set, an idle engine stays idle
  a_r4_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    (ctrl.hold && !busy) |=> !busy);
  // R11: without both enable and master, an idle engine stays idle
  a_r11_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (!(ctrl.en && ctrl.mst) && !busy) |=> !busy);
endmodule

// File: tb/sim_spi_fifo_master.sv
module sim_spi_fifo_master;
  localparam int DW = 8, DEPTH = 4, DIV = 2, SW = 4;
  localparam int WORD_CYC = 2 * DW * DIV + 1;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0, miso_i = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sclk_o, mosi_o;
  logic [SW-1:0] ss_n_o;

  int n_chk = 0, n_fail = 0;
  logic cur_cpol = 0, cur_cpha = 0;
  logic [SW-1:0] exp_ss = '1;
  logic [DW-1:0] mon = 0;
  int mon_bits = 0, ss_bad = 0;

  always #5 clk = ~clk;

  spi_fifo_master #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .CLK_DIV(DIV), .SEL_W(SW)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .ss_n_o(ss_n_o));

  // sampling-edge monitor: leading edge leaves the CPOL level
  always @(sclk_o) begin
    if (!rst && ((sclk_o != cur_cpol) == !cur_cpha)) begin
      mon = {mon[DW-2:0], mosi_o};
      mon_bits++;
      if (ss_n_o != exp_ss) ss_bad++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] on_wire(input logic [DW-1:0] w, input bit lsb);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = w[DW-1-i];
    return lsb ? r : w;
  endfunction

  function automatic logic [31:0] ctrl_word(input bit loop, en, mst, cpol, cpha, man, hold, lsb);
    return {22'd0, lsb, hold, man, 2'b00, cpha, cpol, mst, en, loop};
  endfunction

  task automatic set_ctrl(input logic [31:0] c);
    wr(8'h60, c);
    cur_cpol = c[3]; cur_cpha = c[4];
    idle(2);
    mon = 0; mon_bits = 0; ss_bad = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 0;
    idle(1);

    // R1 / R3 / R12 reset state
    rd(8'h60, v); check(v == 0, "R1 ctrl reset", v, 0);
    rd(8'h70, v); check(v == 32'hFFFF_FFFF, "R1 select reset", v, 32'hFFFF_FFFF);
    check(sclk_o == 0 && ss_n_o == 4'hF, "R1 pins reset", {sclk_o, ss_n_o}, 5'h0F);
    rd(8'h64, v); check(v == 32'h05, "R3 status reset", v, 32'h05);
    check(v[4] == 0, "R12 mode fault low", v[4], 0);

    // R2 readback, flush bits read zero
    wr(8'h60, 32'h3FF);
    rd(8'h60, v); check(v == 32'h39F, "R2 ctrl readback", v, 32'h39F);
    set_ctrl(ctrl_word(0, 1, 1, 0, 0, 1, 1, 0));

    // R9 depth discovery with hold set, R4 no shifting
    cnt = 0;
    do begin
      wr(8'h68, 32'hA0 + cnt);
      cnt++;
      rd(8'h64, v);
    end while (!v[3] && cnt < 64);
    check(cnt == DEPTH, "R9 depth count", cnt, DEPTH);
    wr(8'h68, 32'hEE);
    idle(40);
    rd(8'h64, v); check(v[0] == 1 && v[2] == 0, "R4 held no transfer", v, 32'h09);
    check(mon_bits == 0 && sclk_o == 0, "R4 sclk quiet", mon_bits, 0);

    // R4 release: back-to-back burst
    wr(8'h60, ctrl_word(1, 1, 1, 0, 0, 1, 0, 0));
    idle(DEPTH * WORD_CYC + 2);
    rd(8'h64, v); check(v[1] == 1 && v[2] == 1, "R4 burst complete", v, 32'h06);
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h6C, v); check(v == 32'hA0 + i, "R5 loopback order", v, 32'hA0 + i);
    end
    // R9 the dropped fifth word never arrives; R10 empty read
    rd(8'h6C, v); check(v == 0, "R10 empty read zero", v, 0);
    rd(8'h64, v); check(v[0] == 1, "R10 still empty", v, 1);

    // R2 TX flush
    set_ctrl(ctrl_word(1, 1, 1, 0, 0, 1, 1, 0));
    wr(8'h68, 32'h12); wr(8'h68, 32'h34);
    wr(8'h60, ctrl_word(1, 1, 1, 0, 0, 1, 1, 0) | 32'h20);
    rd(8'h64, v); check(v[2] == 1, "R2 tx flush", v, 32'h04);
    rd(8'h60, v); check(v[5] == 0, "R2 flush bit reads zero", v[5], 0);
    // R2 RX flush
    wr(8'h68, 32'h56);
    wr(8'h60, ctrl_word(1, 1, 1, 0, 0, 1, 0, 0));
    idle(WORD_CYC + 3);
    rd(8'h64, v); check(v[0] == 0, "R5 one word received", v, 0);
    wr(8'h60, ctrl_word(1, 1, 1, 0, 0, 1, 0, 0) | 32'h40);
    rd(8'h64, v); check(v[0] == 1, "R2 rx flush", v, 1);

    // R11 enable gating
    set_ctrl(ctrl_word(1, 0, 1, 0, 0, 1, 0, 0));
    wr(8'h68, 32'h5A);
    idle(WORD_CYC + 5);
    rd(8'h64, v); check(v[2] == 0 && v[0] == 1, "R11 no start without enable", v, 32'h01);
    wr(8'h60, ctrl_word(1, 1, 1, 0, 0, 1, 0, 0));
    idle(WORD_CYC + 3);
    rd(8'h6C, v); check(v == 32'h5A, "R11 starts once enabled", v, 32'h5A);

    // R8 automatic select
    wr(8'h70, 32'hFFFF_FFFD);
    exp_ss = 4'hD;
    set_ctrl(ctrl_word(1, 1, 1, 0, 0, 0, 0, 0));
    check(ss_n_o == 4'hF, "R8 auto idle high", ss_n_o, 4'hF);
    wr(8'h68, 32'hC3);
    idle(WORD_CYC + 3);
    check(ss_bad == 0 && mon_bits == DW, "R8 auto select during word", ss_bad, 0);
    check(ss_n_o == 4'hF, "R8 auto released", ss_n_o, 4'hF);
    rd(8'h6C, v);

    // R5 external MISO
    for (int b = 0; b < 2; b++) begin
      miso_i = b[0];
      set_ctrl(ctrl_word(0, 1, 1, 0, 0, 1, 0, 0));
      wr(8'h68, 32'h3C);
      idle(WORD_CYC + 3);
      rd(8'h6C, v);
      check(v == (b ? 32'hFF : 32'h00), "R5 miso capture", v, b ? 32'hFF : 32'h00);
    end

    // R6 / R7 / R8 / R5 random modes in loopback, manual select
    for (int it = 0; it < 24; it++) begin
      logic [DW-1:0] w;
      bit pol, pha, lsb;
      logic [SW-1:0] s;
      w = DW'($urandom);
      pol = $urandom_range(0, 1); pha = $urandom_range(0, 1); lsb = $urandom_range(0, 1);
      s = ~(SW'(1) << $urandom_range(0, SW - 1));
      if (it < 4) begin pol = it[0]; pha = it[1]; end
      wr(8'h70, {28'hFFFFFFF, s});
      exp_ss = s;
      set_ctrl(ctrl_word(1, 1, 1, pol, pha, 1, 0, lsb));
      check(sclk_o == pol, "R6 idle level", sclk_o, pol);
      check(ss_n_o == s, "R8 manual select", ss_n_o, s);
      wr(8'h68, {24'd0, w});
      idle(WORD_CYC + 3);
      check(mon_bits == DW && mon == on_wire(w, lsb), "R6 R7 wire order", mon, on_wire(w, lsb));
      check(ss_bad == 0, "R8 select held", ss_bad, 0);
      rd(8'h6C, v); check(v == {24'd0, w}, "R5 loopback word", v, {24'd0, w});
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule